// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching translation descriptors from memory one after another. A walk starts at a context slot selected by a 4-bit context number. It then follows pointer descriptors through a region table, a segment table and a page table until it reaches a leaf descriptor.

At the leaf, the walker checks the 3-bit permission code against the privilege of the requester and the kind of access. If the access is allowed, it updates the referenced and modified flags in the descriptor, writing the descriptor back only when a flag changes. It then reports the physical address and whether the page may be cached. A walk that cannot complete reports a fault kind and the table level at which it stopped.

A leaf may also appear in the region table or the segment table. Such a leaf maps a large page, and more low-order virtual address bits pass straight through. Memory is reached through a port that carries one request at a time and waits for the matching response before it issues the next one.

Top module: `mmu_walker`

## Requirements
- R1: The first read of a walk is at `ctx_tbl_base + 4*req_ctx`. Each later read is at the child table base plus 4 times the index. The index is taken from VA bits 31:24 in the region table (level 1), bits 23:18 in the segment table (level 2) and bits 17:12 in the page table (level 3).
- R2: The descriptor type is in bits 1:0: 0 invalid, 1 pointer, 2 leaf, 3 reserved.
  - Type 0 gives fault kind 1, and type 3 gives fault kind 2.
  - A pointer read from the page table (level 3) also gives fault kind 1.
  - `fault_level` reports the level of the descriptor that failed: 0 for the context slot, 1 to 3 for the tables.
- R3: A pointer descriptor gives the child table base as its bits 31:2 placed at physical address bits 35:6, with the low six bits zero.
- R4: A leaf at level 3 gives PA = {descriptor bits 31:8, VA bits 11:0}.
- R5: A leaf at level 1 gives PA = {descriptor bits 31:20, VA bits 23:0}, and a leaf at level 2 gives PA = {descriptor bits 31:14, VA bits 17:0]. A leaf found in the context slot gives fault kind 1 at level 0.
- R6: The leaf permission code is in bits 4:2. `req_acc` is 0 for read, 1 for write and 2 for execute. The rights per code, written as user / supervisor, are:
  - 0: R / R
  - 1: RW / RW
  - 2: RX / RX
  - 3: RWX / RWX
  - 4: X / X
  - 5: R / RW
  - 6: none / RX
  - 7: none / RWX

  An access that is not allowed gives fault kind 4.
- R7: A user access (`req_user`=1) to a leaf with code 6 or 7 gives fault kind 3, whatever the access type.
- R8: On success, the new descriptor is the old one with bit 5 (referenced) set, and also bit 6 (modified) set for a write. It is written to the address it was read from, only when it differs from the old value. That write is acknowledged before `done`.
- R9: On success, `cacheable` equals leaf bit 7.
- R10: `req_ready` is high only when the walker is idle. A `req_valid` pulse while busy is ignored, and at most one memory request is outstanding.
- R11: `done` is high for exactly one cycle per walk.
  - On a fault, no write is issued, and `pa` and `cacheable` read 0.
  - On success, `fault`, `fault_kind` and `fault_level` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken when req_ready) |
| req_ready | output | 1 | Walker idle |
| req_va | input | 32 | Virtual address |
| req_ctx | input | 4 | Context number |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| req_acc | input | 2 | 0 read, 1 write, 2 execute |
| ctx_tbl_base | input | 36 | Physical base of the context table |
| mem_req_valid | output | 1 | Memory request strobe (one cycle) |
| mem_req_write | output | 1 | 1 = write-back, 0 = read |
| mem_req_addr | output | 36 | Descriptor address |
| mem_req_wdata | output | 32 | Updated descriptor |
| mem_rsp_valid | input | 1 | Response / acknowledge |
| mem_rsp_rdata | input | 32 | Descriptor read data |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk failed |
| fault_kind | output | 3 | 0 none, 1 invalid, 2 reserved, 3 privilege, 4 access |
| fault_level | output | 2 | Level of the failing descriptor |
| pa | output | 36 | Physical address |
| cacheable | output | 1 | Leaf cacheable flag |

## Verification
A new request can arrive in the same cycle that the walker is busy with a fetch or a write-back. The bench provokes this by pulsing `req_valid` with a different address in the middle of a walk. It judges the result by `req_ready` being low at that moment, and by the original walk's result and memory writes matching the independent model. The permission decision and the flag update are also decided from the same response beat. Cases where the flags already hold their final values, and cases where they do not, show whether the write-back is skipped or issued in that same decision.

// File: rtl/mmu_walk_pkg.sv
package mmu_walk_pkg;

   typedef enum logic [1:0] {
      ET_INV  = 2'd0,
      ET_PTR  = 2'd1,
      ET_LEAF = 2'd2,
      ET_RSVD = 2'd3
   } ent_type_e;

   typedef enum logic [2:0] {
      FK_NONE     = 3'd0,
      FK_INVALID  = 3'd1,
      FK_RESERVED = 3'd2,
      FK_PRIV     = 3'd3,
      FK_ACCESS   = 3'd4
   } fault_kind_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD,
      S_RWAIT,
      S_WB,
      S_WWAIT,
      S_FIN
   } walk_state_e;

   localparam logic [1:0] ACC_WRITE = 2'd1;
   localparam logic [1:0] ACC_EXEC  = 2'd2;

   localparam int BIT_REF   = 5;
   localparam int BIT_MOD   = 6;
   localparam int BIT_CACHE = 7;

endpackage

// File: rtl/mmu_walk_perm.sv
module mmu_walk_perm
   import mmu_walk_pkg::*;
(
   input  logic [2:0] code,
   input  logic       user,
   input  logic [1:0] acc,
   output logic       priv_fault,
   output logic       acc_fault
);

   logic can_r, can_w, can_x;

   always_comb begin
      // supervisor view first
      can_r = (code != 3'd4);
      can_w = code[0];
      can_x = (code == 3'd2) || (code == 3'd3) || (code == 3'd4) || code[2] & code[1];
      // user view narrows code 5 to read only
      if (user && code == 3'd5) begin
         can_w = 1'b0;
      end
      priv_fault = user & code[2] & code[1];
      if (acc == ACC_WRITE) begin
         acc_fault = ~priv_fault & ~can_w;
      end else if (acc == ACC_EXEC) begin
         acc_fault = ~priv_fault & ~can_x;
      end else begin
         acc_fault = ~priv_fault & ~can_r;
      end
   end

endmodule

// File: rtl/mmu_walk_eaddr.sv
module mmu_walk_eaddr #(
   parameter int CTX_W = 4,
   parameter int RGN_W = 8,
   parameter int SEG_W = 6,
   parameter int PG_W  = 6,
   parameter int OFF_W = 12,
   parameter int ENT_W = 32,
   parameter int PA_W  = 36,
   localparam int VPN_W   = RGN_W + SEG_W + PG_W,
   localparam int BASE_SH = PA_W - (ENT_W - 2)
) (
   input  logic [1:0]         level,
   input  logic [PA_W-1:0]    ctx_base,
   input  logic [CTX_W-1:0]   ctx,
   input  logic [VPN_W-1:0]   vpn,
   input  logic [ENT_W-3:0]   ptr_hi,
   output logic [PA_W-1:0]    addr
);

   logic [PA_W-1:0] base;
   logic [PA_W-1:0] idx;

   always_comb begin
      base = PA_W'(ptr_hi) << BASE_SH;
      case (level)
         2'd0: begin
            base = ctx_base;
            idx  = PA_W'(ctx);
         end
         2'd1:    idx = PA_W'(vpn[VPN_W-1 -: RGN_W]);
         2'd2:    idx = PA_W'(vpn[PG_W +: SEG_W]);
         default: idx = PA_W'(vpn[PG_W-1:0]);
      endcase
      addr = base + (idx << 2);
   end

endmodule

// File: rtl/mmu_walk_pa.sv
module mmu_walk_pa #(
   parameter int SEG_W = 6,
   parameter int PG_W  = 6,
   parameter int OFF_W = 12,
   parameter int PPN_W = 24,
   parameter int VA_W  = 32,
   localparam int PA_W = PPN_W + OFF_W,
   localparam int K3   = OFF_W,
   localparam int K2   = OFF_W + PG_W,
   localparam int K1   = OFF_W + PG_W + SEG_W
) (
   input  logic [1:0]        level,
   input  logic [PPN_W-1:0]  ppn,
   input  logic [VA_W-1:0]   va,
   output logic [PA_W-1:0]   pa
);

   localparam logic [PA_W-1:0] KEEP1 = (PA_W'(1) << K1) - PA_W'(1);
   localparam logic [PA_W-1:0] KEEP2 = (PA_W'(1) << K2) - PA_W'(1);
   localparam logic [PA_W-1:0] KEEP3 = (PA_W'(1) << K3) - PA_W'(1);

   logic [PA_W-1:0] keep;
   logic [PA_W-1:0] frame;

   always_comb begin
      case (level)
         2'd1:    keep = KEEP1;
         2'd2:    keep = KEEP2;
         default: keep = KEEP3;
      endcase
      frame = {ppn, {OFF_W{1'b0}}};
      pa    = (frame & ~keep) | (PA_W'(va) & keep);
   end

endmodule

// File: rtl/mmu_walker.sv
module mmu_walker
   import mmu_walk_pkg::*;
#(
   parameter int CTX_W      = 4,
   parameter int RGN_W      = 8,
   parameter int SEG_W      = 6,
   parameter int PG_W       = 6,
   parameter int OFF_W      = 12,
   parameter bit LARGE_LEAF = 1'b1,
   localparam int ENT_W = 32,
   localparam int VA_W  = RGN_W + SEG_W + PG_W + OFF_W,
   localparam int PPN_W = ENT_W - 8,
   localparam int PA_W  = PPN_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_va,
   input  logic [CTX_W-1:0]  req_ctx,
   input  logic              req_user,
   input  logic [1:0]        req_acc,
   input  logic [PA_W-1:0]   ctx_tbl_base,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [PA_W-1:0]   mem_req_addr,
   output logic [ENT_W-1:0]  mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [ENT_W-1:0]  mem_rsp_rdata,
   output logic              done,
   output logic              fault,
   output logic [2:0]        fault_kind,
   output logic [1:0]        fault_level,
   output logic [PA_W-1:0]   pa,
   output logic              cacheable
);

   localparam logic [1:0] LVL_PAGE = 2'd3;

   if (VA_W != 32) begin : g_bad_va
      $error("mmu_walker: index and offset widths must sum to 32");
   end
   if (PA_W < ENT_W) begin : g_bad_pa
      $error("mmu_walker: physical address narrower than a descriptor");
   end

   walk_state_e        state;
   logic [1:0]         level_q;
   logic [VA_W-1:0]    va_q;
   logic [CTX_W-1:0]   ctx_q;
   logic               user_q;
   logic [1:0]         acc_q;
   logic [PA_W-1:0]    cbase_q;
   logic [ENT_W-1:0]   ptr_q;
   logic [PA_W-1:0]    addr_q;
   logic [ENT_W-1:0]   wdata_q;
   logic [PA_W-1:0]    pa_q;
   logic               cache_q;
   logic               fault_q;
   fault_kind_e        kind_q;
   logic [1:0]         flvl_q;

   logic [PA_W-1:0]    ent_addr;
   logic [PA_W-1:0]    leaf_pa;
   logic               priv_f, acc_f;
   logic               leaf_lvl_ok;
   ent_type_e          rsp_type;
   fault_kind_e        rsp_fault;
   logic [ENT_W-1:0]   upd_ent;

   mmu_walk_eaddr #(
      .CTX_W(CTX_W), .RGN_W(RGN_W), .SEG_W(SEG_W), .PG_W(PG_W),
      .OFF_W(OFF_W), .ENT_W(ENT_W), .PA_W(PA_W)
   ) eaddr_i (
      .level    (level_q),
      .ctx_base (cbase_q),
      .ctx      (ctx_q),
      .vpn      (va_q[VA_W-1:OFF_W]),
      .ptr_hi   (ptr_q[ENT_W-1:2]),
      .addr     (ent_addr)
   );

   mmu_walk_pa #(
      .SEG_W(SEG_W), .PG_W(PG_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .VA_W(VA_W)
   ) pa_i (
      .level (level_q),
      .ppn   (mem_rsp_rdata[ENT_W-1:8]),
      .va    (va_q),
      .pa    (leaf_pa)
   );

   mmu_walk_perm perm_i (
      .code       (mem_rsp_rdata[4:2]),
      .user       (user_q),
      .acc        (acc_q),
      .priv_fault (priv_f),
      .acc_fault  (acc_f)
   );

   if (LARGE_LEAF) begin : g_large
      assign leaf_lvl_ok = (level_q != 2'd0);
   end else begin : g_small
      assign leaf_lvl_ok = (level_q == LVL_PAGE);
   end

   assign rsp_type = ent_type_e'(mem_rsp_rdata[1:0]);
   assign upd_ent  = mem_rsp_rdata
                   | (ENT_W'(1) << BIT_REF)
                   | ((acc_q == ACC_WRITE) ? (ENT_W'(1) << BIT_MOD) : '0);

   always_comb begin
      rsp_fault = FK_NONE;
      case (rsp_type)
         ET_INV:  rsp_fault = FK_INVALID;
         ET_RSVD: rsp_fault = FK_RESERVED;
         ET_PTR: begin
            if (level_q == LVL_PAGE) rsp_fault = FK_INVALID;
         end
         default: begin
            if (!leaf_lvl_ok)  rsp_fault = FK_INVALID;
            else if (priv_f)   rsp_fault = FK_PRIV;
            else if (acc_f)    rsp_fault = FK_ACCESS;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         level_q <= '0;
         va_q    <= '0;
         ctx_q   <= '0;
         user_q  <= 1'b0;
         acc_q   <= '0;
         cbase_q <= '0;
         ptr_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         pa_q    <= '0;
         cache_q <= 1'b0;
         fault_q <= 1'b0;
         kind_q  <= FK_NONE;
         flvl_q  <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_va;
                  ctx_q   <= req_ctx;
                  user_q  <= req_user;
                  acc_q   <= req_acc;
                  cbase_q <= ctx_tbl_base;
                  level_q <= 2'd0;
                  state   <= S_RD;
               end
            end
            S_RD: begin
               addr_q <= ent_addr;
               state  <= S_RWAIT;
            end
            S_RWAIT: begin
               if (mem_rsp_valid) begin
                  if (rsp_fault != FK_NONE) begin
                     fault_q <= 1'b1;
                     kind_q  <= rsp_fault;
                     flvl_q  <= level_q;
                     pa_q    <= '0;
                     cache_q <= 1'b0;
                     state   <= S_FIN;
                  end else if (rsp_type == ET_PTR) begin
                     ptr_q   <= mem_rsp_rdata;
                     level_q <= level_q + 2'd1;
                     state   <= S_RD;
                  end else begin
                     fault_q <= 1'b0;
                     kind_q  <= FK_NONE;
                     flvl_q  <= '0;
                     pa_q    <= leaf_pa;
                     cache_q <= mem_rsp_rdata[BIT_CACHE];
                     wdata_q <= upd_ent;
                     state   <= (upd_ent != mem_rsp_rdata) ? S_WB : S_FIN;
                  end
               end
            end
            S_WB:    state <= S_WWAIT;
            S_WWAIT: if (mem_rsp_valid) state <= S_FIN;
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == S_IDLE);
   assign mem_req_valid = (state == S_RD) || (state == S_WB);
   assign mem_req_write = (state == S_WB);
   assign mem_req_addr  = (state == S_WB) ? addr_q : ent_addr;
   assign mem_req_wdata = wdata_q;
   assign done          = (state == S_FIN);
   assign fault         = fault_q;
   assign fault_kind    = kind_q;
   assign fault_level   = flvl_q;
   assign pa            = pa_q;
   assign cacheable     = cache_q;

endmodule

// File: rtl/mmu_walker_chk.sv
module mmu_walker_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       mem_req_valid,
   input logic       mem_req_write,
   input logic       wb_ref,
   input logic [1:0] wb_type,
   input logic       mem_rsp_valid,
   input logic       done,
   input logic       fault,
   input logic [2:0] fault_kind
);

   logic outstanding;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             outstanding <= 1'b0;
      else if (mem_req_valid) outstanding <= 1'b1;
      else if (mem_rsp_valid) outstanding <= 1'b0;
   end

   // R10: never a second request while one is in flight
   p_single_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !outstanding);

   // R10: once a walk is accepted the walker is busy
   p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R8: a write-back carries a leaf with the referenced flag set
   p_wb_leaf_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> (wb_ref && wb_type == 2'b10));

   // R8: the write-back is acknowledged before completion
   p_wb_acked_before_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !outstanding);

   // R11: completion is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: fault flag and fault kind agree at completion
   p_fault_kind_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fault == (fault_kind != 3'd0)));

endmodule

bind mmu_walker mmu_walker_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_write (mem_req_write),
   .wb_ref        (mem_req_wdata[5]),
   .wb_type       (mem_req_wdata[1:0]),
   .mem_rsp_valid (mem_rsp_valid),
   .done          (done),
   .fault         (fault),
   .fault_kind    (fault_kind)
);

// File: tb/mmu_walker_tb_top.sv
module mmu_walker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid, req_ready, req_user;
   logic [31:0] req_va;
   logic [3:0]  req_ctx;
   logic [1:0]  req_acc;
   logic [35:0] ctx_tbl_base;
   logic        mem_req_valid, mem_req_write, mem_rsp_valid;
   logic [35:0] mem_req_addr;
   logic [31:0] mem_req_wdata, mem_rsp_rdata;
   logic        done, fault, cacheable;
   logic [2:0]  fault_kind;
   logic [1:0]  fault_level;
   logic [35:0] pa;

   int checks = 0;
   int errors = 0;
   int wr_count = 0;
   logic [35:0] wr_addr;
   logic [31:0] wr_data;
   logic [31:0] mem [logic [35:0]];

   bit          pend = 1'b0;
   int          lat = 0;
   logic [35:0] pend_addr;
   logic        pend_we;

   always #5 clk = ~clk;

   mmu_walker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_ctx(req_ctx), .req_user(req_user), .req_acc(req_acc),
      .ctx_tbl_base(ctx_tbl_base), .mem_req_valid(mem_req_valid),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .done(done), .fault(fault),
      .fault_kind(fault_kind), .fault_level(fault_level), .pa(pa),
      .cacheable(cacheable)
   );

   function automatic logic [31:0] rd(input logic [35:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [35:0] idx_off(input int l, input logic [31:0] va);
      if (l == 1)      return {26'd0, va[31:24], 2'b00};
      else if (l == 2) return {28'd0, va[23:18], 2'b00};
      else             return {28'd0, va[17:12], 2'b00};
   endfunction

   // rights as {r,w,x}
   function automatic logic [2:0] rwx(input logic [2:0] code, input logic user);
      logic [2:0] u [8] = '{3'b100, 3'b110, 3'b101, 3'b111, 3'b001, 3'b100, 3'b000, 3'b000};
      logic [2:0] s [8] = '{3'b100, 3'b110, 3'b101, 3'b111, 3'b001, 3'b110, 3'b101, 3'b111};
      return user ? u[code] : s[code];
   endfunction

   function automatic logic [31:0] mk_leaf(input logic [23:0] ppn, input logic c,
                                           input logic m, input logic r, input logic [2:0] code);
      return {ppn, c, m, r, code, 2'b10};
   endfunction

   function automatic logic [31:0] mk_ptr(input logic [29:0] b);
      return {b, 2'b01};
   endfunction

   function automatic void ref_walk(
      input  logic [35:0] cb, input logic [3:0] ctx, input logic [31:0] va,
      input  logic user, input logic [1:0] acc,
      output logic f, output logic [2:0] k, output logic [1:0] lv,
      output logic [35:0] epa, output logic c, output logic wb,
      output logic [35:0] wa, output logic [31:0] wd);
      logic [35:0] a;
      logic [31:0] e, n;
      logic [2:0]  m;
      logic        ok;
      bit          fin;
      f = 0; k = 0; lv = 0; epa = 0; c = 0; wb = 0; wa = 0; wd = 0; fin = 0;
      a = cb + {30'd0, ctx, 2'b00};
      for (int l = 0; l < 4; l++) begin
         if (!fin) begin
            e = rd(a);
            case (e[1:0])
               2'd1: begin
                  if (l == 3) begin f = 1; k = 1; lv = 2'(l); fin = 1; end
                  else a = {e[31:2], 6'd0} + idx_off(l + 1, va);
               end
               2'd2: begin
                  fin = 1;
                  m = rwx(e[4:2], user);
                  ok = (acc == 2'd1) ? m[1] : (acc == 2'd2) ? m[0] : m[2];
                  if (l == 0) begin f = 1; k = 1; lv = 0; end
                  else if (user && e[4:2] >= 3'd6) begin f = 1; k = 3; lv = 2'(l); end
                  else if (!ok) begin f = 1; k = 4; lv = 2'(l); end
                  else begin
                     c = e[7];
                     epa = (l == 3) ? {e[31:8], va[11:0]} :
                           (l == 2) ? {e[31:14], va[17:0]} : {e[31:20], va[23:0]};
                     n = e | 32'h20 | ((acc == 2'd1) ? 32'h40 : 32'h0);
                     if (n != e) begin wb = 1; wa = a; wd = n; end
                  end
               end
               2'd3:    begin f = 1; k = 2; lv = 2'(l); fin = 1; end
               default: begin f = 1; k = 1; lv = 2'(l); fin = 1; end
            endcase
         end
      end
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic build(input logic [35:0] cb, input logic [3:0] ctx, input logic [31:0] va,
                        input logic [31:0] e0, input logic [31:0] e1,
                        input logic [31:0] e2, input logic [31:0] e3);
      logic [31:0] es [4];
      logic [35:0] a;
      bit fin = 0;
      mem.delete();
      es[0] = e0; es[1] = e1; es[2] = e2; es[3] = e3;
      a = cb + {30'd0, ctx, 2'b00};
      for (int l = 0; l < 4; l++) begin
         if (!fin) begin
            mem[a] = es[l];
            if (es[l][1:0] == 2'd1 && l < 3) a = {es[l][31:2], 6'd0} + idx_off(l + 1, va);
            else fin = 1;
         end
      end
   endtask

   task automatic run_walk(input string tag, input logic [35:0] cb, input logic [3:0] ctx,
                           input logic [31:0] va, input logic user, input logic [1:0] acc,
                           input bit inject);
      logic ef, ec, ewb;
      logic [2:0] ek;
      logic [1:0] el;
      logic [35:0] epa, ewa;
      logic [31:0] ewd;
      ref_walk(cb, ctx, va, user, acc, ef, ek, el, epa, ec, ewb, ewa, ewd);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      wr_count     = 0;
      req_valid    = 1'b1;
      req_va       = va;
      req_ctx      = ctx;
      req_user     = user;
      req_acc      = acc;
      ctx_tbl_base = cb;
      @(negedge clk);
      req_valid = 1'b0;
      if (inject) begin
         @(negedge clk);
         chk({tag, " R10 busy ready low"}, 64'(req_ready), 64'd0);
         req_valid    = 1'b1;
         req_va       = ~va;
         req_ctx      = ~ctx;
         req_acc      = 2'd1;
         ctx_tbl_base = ~cb;
         @(negedge clk);
         req_valid = 1'b0;
      end
      while (!done) @(negedge clk);
      chk({tag, " fault"}, 64'(fault), 64'(ef));
      chk({tag, " fault_kind"}, 64'(fault_kind), 64'(ek));
      chk({tag, " fault_level"}, 64'(fault_level), 64'(el));
      chk({tag, " pa"}, 64'(pa), 64'(epa));
      chk({tag, " cacheable"}, 64'(cacheable), 64'(ec));
      chk({tag, " R11 write count"}, 64'(wr_count), 64'(ewb));
      if (ewb) begin
         chk({tag, " R8 wb addr"}, 64'(wr_addr), 64'(ewa));
         chk({tag, " R8 wb data"}, 64'(wr_data), 64'(ewd));
      end
      @(negedge clk);
      chk({tag, " R11 done pulse"}, 64'(done), 64'd0);
   endtask

   // memory responder: one request at a time, 1..3 cycles of latency
   initial begin : responder
      mem_rsp_valid = 1'b0;
      mem_rsp_rdata = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (pend) begin
            if (lat == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_rdata = pend_we ? 32'h0 : rd(pend_addr);
               pend = 1'b0;
            end else begin
               lat--;
            end
         end
         if (mem_req_valid) begin
            pend      = 1'b1;
            lat       = $urandom_range(0, 2);
            pend_addr = mem_req_addr;
            pend_we   = mem_req_write;
            if (pend_we) begin
               mem[pend_addr] = mem_req_wdata;
               wr_count++;
               wr_addr = pend_addr;
               wr_data = mem_req_wdata;
            end
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [35:0] cb;
      logic [31:0] p1, p2, p3;
      void'($urandom(32'd4242));
      req_valid = 0; req_va = 0; req_ctx = 0; req_user = 0; req_acc = 0; ctx_tbl_base = 0;
      repeat (3) @(negedge clk);
      chk("R10 reset ready", 64'(req_ready), 64'd1);
      chk("R11 reset done", 64'(done), 64'd0);
      chk("R10 reset no mem req", 64'(mem_req_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      cb = 36'h0_0040_0000;
      p1 = mk_ptr(30'h0001_0000);
      p2 = mk_ptr(30'h0002_0040);
      p3 = mk_ptr(30'h0003_0080);

      build(cb, 4'd3, 32'h1234_5678, p1, p2, p3, mk_leaf(24'hABCDE1, 1, 0, 0, 3'd3));
      run_walk("R1 R3 R4 R8 full read", cb, 4'd3, 32'h1234_5678, 0, 2'd0, 0);

      build(cb, 4'd15, 32'hFEDC_BA98, p1, p2, p3, mk_leaf(24'h123456, 1, 0, 1, 3'd0));
      run_walk("R1 R8 flags unchanged", cb, 4'd15, 32'hFEDC_BA98, 1, 2'd0, 0);

      build(cb, 4'd0, 32'h0004_1FFF, p1, p2, p3, mk_leaf(24'h00FF00, 0, 0, 1, 3'd1));
      run_walk("R9 R8 write uncached", cb, 4'd0, 32'h0004_1FFF, 1, 2'd1, 0);

      build(cb, 4'd7, 32'h89AB_CDEF, p1, mk_leaf(24'hC00000, 1, 0, 0, 3'd1), 0, 0);
      run_walk("R5 region leaf", cb, 4'd7, 32'h89AB_CDEF, 0, 2'd1, 0);

      build(cb, 4'd7, 32'h89AB_CDEF, p1, p2, mk_leaf(24'h5A5A40, 1, 1, 1, 3'd3), 0);
      run_walk("R5 segment leaf", cb, 4'd7, 32'h89AB_CDEF, 0, 2'd2, 0);

      build(cb, 4'd2, 32'h0000_1000, mk_leaf(24'h111111, 1, 0, 0, 3'd3), 0, 0, 0);
      run_walk("R5 context leaf", cb, 4'd2, 32'h0000_1000, 0, 2'd0, 0);

      build(cb, 4'd2, 32'h0ACE_0000, p1, p2, 32'h0000_0000, 0);
      run_walk("R2 invalid level2", cb, 4'd2, 32'h0ACE_0000, 0, 2'd0, 0);

      build(cb, 4'd2, 32'h0ACE_0000, p1, p2, p3, 32'hFFFF_FFFF);
      run_walk("R2 reserved level3", cb, 4'd2, 32'h0ACE_0000, 0, 2'd0, 0);

      build(cb, 4'd2, 32'h0ACE_0000, p1, p2, p3, mk_ptr(30'h1234));
      run_walk("R2 pointer at page level", cb, 4'd2, 32'h0ACE_0000, 0, 2'd0, 0);

      build(cb, 4'd5, 32'h4000_2000, p1, p2, p3, mk_leaf(24'h222222, 1, 0, 0, 3'd6));
      run_walk("R7 user code6", cb, 4'd5, 32'h4000_2000, 1, 2'd0, 0);
      run_walk("R6 sup code6 exec", cb, 4'd5, 32'h4000_2000, 0, 2'd2, 0);

      build(cb, 4'd5, 32'h4000_2000, p1, p2, p3, mk_leaf(24'h222222, 1, 0, 0, 3'd7));
      run_walk("R7 user code7 exec", cb, 4'd5, 32'h4000_2000, 1, 2'd2, 0);

      build(cb, 4'd5, 32'h4000_2000, p1, p2, p3, mk_leaf(24'h333333, 1, 0, 0, 3'd4));
      run_walk("R6 code4 read denied", cb, 4'd5, 32'h4000_2000, 0, 2'd0, 0);

      build(cb, 4'd5, 32'h4000_2000, p1, p2, p3, mk_leaf(24'h444444, 1, 0, 0, 3'd5));
      run_walk("R6 user code5 write", cb, 4'd5, 32'h4000_2000, 1, 2'd1, 0);
      run_walk("R6 sup code5 write", cb, 4'd5, 32'h4000_2000, 0, 2'd1, 0);

      build(cb, 4'd9, 32'h7777_7777, p1, p2, p3, mk_leaf(24'h0BEEF0, 1, 0, 0, 3'd1));
      run_walk("R10 busy ignore", cb, 4'd9, 32'h7777_7777, 0, 2'd1, 1);

      for (int i = 0; i < 300; i++) begin
         logic [35:0] rcb;
         logic [3:0]  rctx;
         logic [31:0] rva;
         logic [31:0] es [4];
         rcb  = {$urandom()[3:0], $urandom()} & ~36'h3;
         rctx = 4'($urandom());
         rva  = $urandom();
         for (int l = 0; l < 4; l++) begin
            int r = $urandom_range(0, 15);
            logic [1:0] t;
            if (l == 0)      t = (r < 13) ? 2'd1 : (r == 13) ? 2'd2 : (r == 14) ? 2'd0 : 2'd3;
            else if (l < 3)  t = (r < 11) ? 2'd1 : (r < 13) ? 2'd2 : (r == 13) ? 2'd0 : 2'd3;
            else             t = (r < 12) ? 2'd2 : (r == 12) ? 2'd1 : (r == 13) ? 2'd0 : 2'd3;
            es[l] = {$urandom()[31:2], t};
         end
         build(rcb, rctx, rva, es[0], es[1], es[2], es[3]);
         run_walk("R3 random", rcb, rctx, rva, 1'($urandom()), 2'($urandom_range(0, 2)), i % 37 == 5);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule